// File: doc/BRIEF.md
# Instrument Status and Service-Request Core

This block holds the status state of a test instrument that follows the IEEE 488.2 reporting scheme. Single-cycle event pulses set sticky bits in an 8-bit standard event register. An event enable mask folds those bits into one event summary bit. That bit sits at position 5 of an 8-bit status byte. The other summary positions of the status byte come from the instrument's own subsystems through `aux_summary`.

Two further masks act on the status byte. The service request mask forms the master summary bit (MSS), which drives the service request output. The parallel poll mask forms the "ist" local message. Both take the OR of the status byte bits other than bit 6, each gated by its mask bit.

A small register port stands in for the command layer. A write is taken on the clock edge. A read is combinational. Reading the event register also clears it.

Top module: `status_core`

## Requirements
- R1: After reset, the event register and the three masks are zero, and `mss`, `srq` and `ist` are 0.
- R2: A 1 on `evt_pulse[i]` sets event bit i at the next clock edge. The bit then stays set until it is cleared.
- R3: A read at address 0 returns the event register and clears it at the same edge. If a pulse arrives in that cycle, its bit is set after the edge.
- R4: Status byte bit 5 is the OR of the event bits ANDed with the event enable mask (address 1).
- R5: Writing 4 to the event enable mask enables only event bit 2, the query error.
- R6: Bit 6 of the service request mask (address 3) ignores writes and always reads back 0.
- R7: `mss` is the OR of status byte bits 0–5 and 7, each ANDed with the matching service request mask bit. `srq` equals `mss`. A read of the status byte (address 2) shows `mss` at bit 6, `aux_summary` at bits 0–4 and 7, and the event summary at bit 5.
- R8: `ist` is the OR of status byte bits 0–5 and 7, each ANDed with the parallel poll mask (address 4). Address 5 reads `ist` in bit 0, with all other bits 0. Writing 5 to the parallel poll mask sets bits 2 and 0.
- R9: Each mask reads back what was written to it and becomes zero when 0 is written. Writes to addresses 0, 2, 5, 6 and 7 change nothing.
- R10: A read at address 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| evt_pulse | input | 8 | Single-cycle standard event pulses |
| aux_summary | input | 8 | Subsystem summary bits; bits 5 and 6 are not used |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; at address 0 it clears the event register |
| rd_data | output | 8 | Combinational read data |
| mss | output | 1 | Master summary status |
| srq | output | 1 | Service request |
| ist | output | 1 | Parallel poll individual status message |

## Verification
The assertions assume that `wr_en` and `rd_en` are never 0 or 1 in an unknown way during reset. They also assume that `aux_summary` has no bearing on the event path. The bench meets both assumptions by driving every input to a known value one nanosecond after a falling edge and holding all strobes low through reset. The random phase covers the clear-versus-set collision of R3: it mixes reads and writes at every address with sparse event pulses, so reads at address 0 often land in the same cycle as a pulse.

// File: rtl/status_pkg.sv
package status_pkg;

  typedef enum logic [2:0] {
    A_EVT  = 3'd0,
    A_EVEN = 3'd1,
    A_SBYT = 3'd2,
    A_SREN = 3'd3,
    A_PPEN = 3'd4,
    A_IST  = 3'd5
  } reg_addr_e;

  localparam int SB_W    = 8;
  localparam int ESB_POS = 5;
  localparam int MSS_POS = 6;
  localparam logic [SB_W-1:0] MSS_BIT = SB_W'(1) << MSS_POS;
  localparam logic [SB_W-1:0] ESB_BIT = SB_W'(1) << ESB_POS;

  // OR of the bits of v selected by m, with the MSS position left out
  function automatic logic masked_any(input logic [SB_W-1:0] v,
                                      input logic [SB_W-1:0] m);
    return |(v & m & ~MSS_BIT);
  endfunction

  // status byte before MSS is inserted
  function automatic logic [SB_W-1:0] base_byte(input logic [SB_W-1:0] aux,
                                                input logic esb);
    return (aux & ~(ESB_BIT | MSS_BIT)) | (esb ? ESB_BIT : '0);
  endfunction

endpackage

// File: rtl/status_evt_reg.sv
module status_evt_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pulse,
  input  logic         clr,
  output logic [W-1:0] evt_q
);
  // one sticky flop per event; a set in the clearing cycle wins
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        evt_q[i] <= 1'b0;
      else if (pulse[i]) evt_q[i] <= 1'b1;
      else if (clr)      evt_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/status_mask_reg.sv
module status_mask_reg #(
  parameter int           W     = 8,
  parameter logic [W-1:0] HOLD0 = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] d_keep;
  assign d_keep = wd & ~HOLD0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d_keep;
  end
endmodule

// File: rtl/status_summary.sv
module status_summary
  import status_pkg::*;
(
  input  logic [SB_W-1:0] aux,
  input  logic            esb,
  input  logic [SB_W-1:0] sre,
  input  logic [SB_W-1:0] pre,
  output logic [SB_W-1:0] sb_full,
  output logic            mss,
  output logic            ist
);
  logic [SB_W-1:0] sb_base;

  always_comb begin
    sb_base = base_byte(aux, esb);
    mss     = masked_any(sb_base, sre);
    ist     = masked_any(sb_base, pre);
    sb_full = sb_base | (mss ? MSS_BIT : '0);
  end
endmodule

// File: rtl/status_core.sv
module status_core
  import status_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic [7:0]       aux_summary,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             mss,
  output logic             srq,
  output logic             ist
);
  // named internal events, visible to the bound checker
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] ese_q;
  logic [SB_W-1:0]  sre_q;
  logic [SB_W-1:0]  pre_q;
  logic             esb;
  logic             evt_clr;
  logic [SB_W-1:0]  sb_full;
  logic             we_ese, we_sre, we_pre;

  assign evt_clr = rd_en && (addr == A_EVT);
  assign we_ese  = wr_en && (addr == A_EVEN);
  assign we_sre  = wr_en && (addr == A_SREN);
  assign we_pre  = wr_en && (addr == A_PPEN);

  status_evt_reg #(.W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .pulse(evt_pulse), .clr(evt_clr), .evt_q(evt_q)
  );

  status_mask_reg #(.W(EVT_W), .HOLD0('0)) u_ese (
    .clk(clk), .rst_n(rst_n), .we(we_ese), .wd(wr_data[EVT_W-1:0]), .q(ese_q)
  );

  status_mask_reg #(.W(SB_W), .HOLD0(MSS_BIT)) u_sre (
    .clk(clk), .rst_n(rst_n), .we(we_sre), .wd(wr_data), .q(sre_q)
  );

  status_mask_reg #(.W(SB_W), .HOLD0('0)) u_pre (
    .clk(clk), .rst_n(rst_n), .we(we_pre), .wd(wr_data), .q(pre_q)
  );

  assign esb = |(evt_q & ese_q);

  status_summary u_sum (
    .aux(aux_summary), .esb(esb), .sre(sre_q), .pre(pre_q),
    .sb_full(sb_full), .mss(mss), .ist(ist)
  );

  assign srq = mss;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_EVT:   rd_data = 8'(evt_q);
      A_EVEN:  rd_data = 8'(ese_q);
      A_SBYT:  rd_data = sb_full;
      A_SREN:  rd_data = sre_q;
      A_PPEN:  rd_data = pre_q;
      A_IST:   rd_data = {7'd0, ist};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/status_core_chk.sv
module status_core_chk #(
  parameter int EVT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] evt_pulse,
  input logic [2:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rd_en,
  input logic [EVT_W-1:0] evt_q,
  input logic [EVT_W-1:0] ese_q,
  input logic [7:0]       sre_q,
  input logic [7:0]       pre_q,
  input logic             esb,
  input logic             mss,
  input logic             srq,
  input logic             ist
);
  p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0 && evt_pulse == '0) |=> (evt_q == '0));

  p_esb_needs_enabled_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    esb |-> (|(evt_q & ese_q)));

  p_sre_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> (sre_q == ($past(wr_data) & 8'hBF)));

  p_mss_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mss |-> (|(sre_q & 8'hBF)));

  p_srq_tracks_mss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srq == mss);

  p_ist_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ist |-> (|(pre_q & 8'hBF)));

  p_pre_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd4) |=> $stable(pre_q));
endmodule

bind status_core status_core_chk #(.EVT_W(EVT_W)) u_chk (.*);

// File: tb/test_status_core.sv
`timescale 1ns/1ps
module test_status_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_pulse = '0;
  logic [7:0] aux_summary = '0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       mss, srq, ist;

  always #10 clk = ~clk;

  status_core i_status_core (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .aux_summary(aux_summary),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .mss(mss), .srq(srq), .ist(ist)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_evt = 0, m_ese = 0, m_sre = 0, m_pre = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_sb();
    int sb;
    int summ;
    sb = aux_summary & 'h9F;
    if ((m_evt & m_ese) != 0) sb = sb + 32;
    summ = ((sb & m_sre & 'hBF) != 0) ? 1 : 0;
    return sb + 64 * summ;
  endfunction

  function automatic int ref_ist();
    return ((ref_sb() & m_pre & 'hBF) != 0) ? 1 : 0;
  endfunction

  function automatic int ref_rd();
    case (addr)
      3'd0: return m_evt;
      3'd1: return m_ese;
      3'd2: return ref_sb();
      3'd3: return m_sre;
      3'd4: return m_pre;
      3'd5: return ref_ist();
      default: return 0;
    endcase
  endfunction

  // compare all outputs, then advance one clock and update the model
  task automatic step(input string rd_req);
    int nxt;
    #2;
    check(rd_req, rd_data, ref_rd());
    check("R7 mss", mss, (ref_sb() / 64) % 2);
    check("R7 srq", srq, (ref_sb() / 64) % 2);
    check("R8 ist", ist, ref_ist());
    nxt = m_evt;
    if (rd_en && addr == 3'd0) nxt = 0;
    nxt = nxt | evt_pulse;
    if (wr_en && addr == 3'd1) m_ese = wr_data;
    if (wr_en && addr == 3'd3) m_sre = wr_data & 'hBF;
    if (wr_en && addr == 3'd4) m_pre = wr_data;
    m_evt = nxt;
    @(posedge clk);
    @(negedge clk);
    #1;
    evt_pulse = '0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1; step("R9 write cycle");
  endtask

  task automatic peek(input logic [2:0] a);
    addr = a; #2;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    for (int a = 0; a < 6; a++) begin
      peek(3'(a)); check("R1 reset readback", rd_data, 0);
    end
    check("R1 reset mss", mss, 0);
    check("R1 reset ist", ist, 0);
    rst_n = 1;
    @(negedge clk); #1;

    // R6: bit 6 of service request mask stays zero
    wr(3'd3, 8'hFF);
    peek(3'd3); check("R6 sre bit6 reads 0", rd_data, 8'hBF);
    wr(3'd3, 8'h00);

    // R5: query error only
    wr(3'd1, 8'd4);
    peek(3'd1); check("R5 ese value", rd_data, 4);
    evt_pulse = 8'h01; addr = 3'd2; step("R4 no esb yet");
    peek(3'd2); check("R5 non-enabled event no esb", rd_data, 0);
    evt_pulse = 8'h04; step("R2 pulse");
    peek(3'd2); check("R5 query error drives esb", rd_data, 8'h20);
    peek(3'd0); check("R2 sticky bits", rd_data, 8'h05);

    // R7: esb enabled for service request -> mss
    wr(3'd3, 8'h20);
    peek(3'd2); check("R7 status byte with mss", rd_data, 8'h60);
    check("R7 srq high", srq, 1);

    // R8: parallel poll mask 5 and ist readout
    wr(3'd4, 8'd5);
    peek(3'd4); check("R8 pre 5", rd_data, 5);
    aux_summary = 8'h04; peek(3'd5); check("R8 ist via bit 2", rd_data, 1);
    aux_summary = 8'h40; peek(3'd5); check("R8 bit6 aux ignored", rd_data, 0);
    aux_summary = 8'h00;

    // R3: read-clear with colliding pulse
    addr = 3'd0; rd_en = 1; evt_pulse = 8'h80; step("R3 read returns pre-clear");
    peek(3'd0); check("R3 set wins over clear", rd_data, 8'h80);
    addr = 3'd0; rd_en = 1; step("R3 read");
    peek(3'd0); check("R3 cleared", rd_data, 0);

    // R9: read-only writes ignored, zero write clears
    evt_pulse = 8'h04; addr = 3'd0; step("R2 pulse");
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    peek(3'd0); check("R9 event reg untouched", rd_data, 8'h04);
    peek(3'd3); check("R9 sre untouched", rd_data, 8'h20);
    wr(3'd4, 8'h00); peek(3'd4); check("R9 pre cleared", rd_data, 0);
    peek(3'd6); check("R10 unused addr", rd_data, 0);

    // random phase against the reference model
    for (int i = 0; i < 4000; i++) begin
      addr        = 3'($urandom_range(0, 7));
      wr_en       = ($urandom_range(0, 3) == 0);
      rd_en       = ($urandom_range(0, 2) == 0);
      wr_data     = 8'($urandom);
      aux_summary = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      evt_pulse   = ($urandom_range(0, 4) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      step("R9 R10 readback");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule